// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a four-bit decade counter made of two sections that can be advanced separately. A divide-by-two stage drives bit 0 of the count. A divide-by-five stage drives bits 3 to 1 as a binary value from 0 to 4. Each section steps on falling edges of its own count input. Both count inputs are sampled on the system clock, synchronized, and edge-detected inside the block.

A two-bit mode input sets how the two sections are joined:

- **BCD mode** chains bit 0 into the divide-by-five stage, so the outputs run 0 to 9 in 8421 order.
- **Bi-quinary mode** chains bit 3 into the divide-by-two stage, so bit 0 becomes a square wave with 50% duty cycle at one tenth of the input edge rate.
- **Split mode** keeps the two dividers independent.

A pair of clear inputs, when both are high, holds the count at zero. A pair of preset inputs, when both are high, holds the count at nine and wins over the clear pair. Both pairs act on the system clock.

Top module: `dcnt_decade`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q_o` becomes 4'b0000.
- R2: In split mode (`mode_i` = 2 or 3), each falling edge on `cnt0_i` inverts `q_o[0]`. Edges on `cnt1_i` and wraps of the upper stage leave `q_o[0]` unchanged.
- R3: In split mode, each falling edge on `cnt1_i` steps `q_o[3:1]` through 0,1,2,3,4 and then back to 0. Its value never exceeds 4.
- R4: In BCD mode (`mode_i` = 0), each falling edge on `cnt0_i` advances `q_o` by one, from 0 to 9, and 9 is followed by 0. This includes the case where 9 was loaded by preset.
- R5: In bi-quinary mode (`mode_i` = 1), each falling edge on `cnt1_i` steps `q_o[3:1]` modulo 5. Each wrap from 4 to 0 inverts `q_o[0]`, so `q_o[0]` is high for five input edges and low for five.
- R6: When `clr_a_i` and `clr_b_i` are both high and the preset pair is not both high, `q_o` is 0 after the next clock edge. Count edges that arrive during that time are discarded.
- R7: When `nine_a_i` and `nine_b_i` are both high, `q_o` is 4'b1001 after the next clock edge, whatever the clear inputs and count inputs are doing.
- R8: If only one input of a pair is high, that pair has no effect, and counting proceeds normally.
- R9: Rising edges on the count inputs do not change `q_o`. A change of `mode_i` does not change `q_o` and only affects how later edges are routed.
- R10: In BCD mode the carry into the upper stage is registered. `q_o[3:1]` therefore moves one clock cycle after `q_o[0]` falls, and only when that fall was caused by counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt0_i | input | 1 | Count input of the divide-by-two stage |
| cnt1_i | input | 1 | Count input of the divide-by-five stage |
| mode_i | input | 2 | 0 BCD, 1 bi-quinary, 2 or 3 split |
| clr_a_i | input | 1 | Clear request, first input of the pair |
| clr_b_i | input | 1 | Clear request, second input of the pair |
| nine_a_i | input | 1 | Preset-to-nine request, first input of the pair |
| nine_b_i | input | 1 | Preset-to-nine request, second input of the pair |
| q_o | output | 4 | Count value: bit 0 from the divide-by-two stage, bits 3:1 from the divide-by-five stage |

## Verification
On every cycle, the assertions check the following:
- the clear and preset overrides and their priority;
- that the upper stage never leaves the range 0 to 4;
- that neither stage moves unless it has an advance request.

Some behaviours need whole edge sequences and can only be shown by the bench's scenarios:
- the full 0 to 9 BCD sequence;
- the five-high, five-low shape of the bi-quinary output;
- that single-input pairs, rising edges and mode changes leave the count alone;
- that split mode keeps the stages apart.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int QUIN_MOD = 5;
    localparam int QUIN_W   = $clog2(QUIN_MOD);

    typedef enum logic [1:0] {
        MODE_BCD   = 2'd0,
        MODE_BIQ   = 2'd1,
        MODE_SPLIT = 2'd2
    } mode_t;

    typedef struct packed {
        logic [QUIN_W-1:0] quin;
        logic              bin;
    } count_t;

    function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] v);
        return (v == QUIN_W'(QUIN_MOD - 1)) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [QUIN_W-1:0] quin_top();
        return QUIN_W'(QUIN_MOD - 1);
    endfunction

endpackage

// File: rtl/dcnt_fall_det.sv
module dcnt_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], raw};
    end

    assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/dcnt_div2.sv
module dcnt_div2 (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic adv,
    output logic q,
    output logic carry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= 1'b0;
            carry <= 1'b0;
        end else begin
            carry <= 1'b0;
            if (set)      q <= 1'b1;
            else if (clr) q <= 1'b0;
            else if (adv) begin
                q     <= ~q;
                carry <= q;
            end
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr && !adv) |=> $stable(q));
    p_preset_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
endmodule

// File: rtl/dcnt_div5.sv
module dcnt_div5
    import dcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic              adv,
    output logic [QUIN_W-1:0] quin,
    output logic              carry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            quin  <= '0;
            carry <= 1'b0;
        end else begin
            carry <= 1'b0;
            if (set)      quin <= quin_top();
            else if (clr) quin <= '0;
            else if (adv) begin
                quin  <= quin_next(quin);
                carry <= (quin == quin_top());
            end
        end
    end

    p_range_r3: assert property (@(posedge clk) disable iff (rst)
        quin <= quin_top());
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr && !adv) |=> $stable(quin));
endmodule

// File: rtl/dcnt_decade.sv
module dcnt_decade
    import dcnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt0_i,
    input  logic       cnt1_i,
    input  logic [1:0] mode_i,
    input  logic       clr_a_i,
    input  logic       clr_b_i,
    input  logic       nine_a_i,
    input  logic       nine_b_i,
    output logic [3:0] q_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in, fall;
    logic           set_c, clr_c;
    logic           adv0, adv1, carry2, carry5;
    count_t         st;
    mode_t          mode;

    assign raw_in = {cnt1_i, cnt0_i};
    assign mode   = (mode_i == 2'd0) ? MODE_BCD :
                    (mode_i == 2'd1) ? MODE_BIQ : MODE_SPLIT;

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        dcnt_fall_det #(.STAGES(SYNC_STAGES)) u_det (
            .clk (clk),
            .rst (rst),
            .raw (raw_in[i]),
            .fall(fall[i])
        );
    end

    assign set_c = nine_a_i & nine_b_i;
    assign clr_c = clr_a_i & clr_b_i & ~set_c;

    assign adv0 = (mode == MODE_BIQ) ? carry5 : fall[0];
    assign adv1 = (mode == MODE_BCD) ? carry2 : fall[1];

    dcnt_div2 u_div2 (
        .clk  (clk),
        .rst  (rst),
        .set  (set_c),
        .clr  (clr_c),
        .adv  (adv0),
        .q    (st.bin),
        .carry(carry2)
    );

    dcnt_div5 u_div5 (
        .clk  (clk),
        .rst  (rst),
        .set  (set_c),
        .clr  (clr_c),
        .adv  (adv1),
        .quin (st.quin),
        .carry(carry5)
    );

    assign q_o = st;

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (q_o == 4'b0000));
    p_preset_r7: assert property (@(posedge clk) disable iff (rst)
        (nine_a_i && nine_b_i) |=> (q_o == 4'b1001));
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (q_o == 4'b0000));
endmodule

// File: tb/tb_dcnt_decade.sv
module tb_dcnt_decade;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt0_i = 1'b0, cnt1_i = 1'b0;
    logic [1:0] mode_i = 2'd2;
    logic       clr_a_i = 1'b0, clr_b_i = 1'b0, nine_a_i = 1'b0, nine_b_i = 1'b0;
    logic [3:0] q_o;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dcnt_decade dut (
        .clk(clk), .rst(rst), .cnt0_i(cnt0_i), .cnt1_i(cnt1_i), .mode_i(mode_i),
        .clr_a_i(clr_a_i), .clr_b_i(clr_b_i), .nine_a_i(nine_a_i), .nine_b_i(nine_b_i),
        .q_o(q_o)
    );

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        n_chk++;
        if (q_o !== exp) begin
            n_fail++;
            $display("FAIL %s: q_o=%b expected %b", req, q_o, exp);
        end
    endtask

    task automatic pulse(input int ch);
        if (ch == 0) cnt0_i = 1'b1; else cnt1_i = 1'b1;
        wait_n(4);
        if (ch == 0) cnt0_i = 1'b0; else cnt1_i = 1'b0;
        wait_n(8);
    endtask

    task automatic do_clear();
        clr_a_i = 1'b1; clr_b_i = 1'b1;
        wait_n(1);
        clr_a_i = 1'b0; clr_b_i = 1'b0;
        wait_n(2);
    endtask

    task automatic t_reset();
        wait_n(3);
        chk("R1 reset", 4'b0000);
        rst = 1'b0;
        wait_n(2);
    endtask

    task automatic t_split();
        mode_i = 2'd2;
        pulse(0);
        chk("R2 split toggle", 4'b0001);
        pulse(1);
        chk("R3 split step / R2 q0 kept", 4'b0011);
        for (int i = 0; i < 3; i++) pulse(1);
        chk("R3 split reaches 4", 4'b1001);
        pulse(1);
        chk("R3 split wrap, R2 no cascade", 4'b0001);
        cnt0_i = 1'b1;
        wait_n(8);
        chk("R9 rising edge ignored", 4'b0001);
        cnt0_i = 1'b0;
        wait_n(8);
        chk("R2 falling edge toggles", 4'b0000);
    endtask

    task automatic t_bcd();
        do_clear();
        chk("R6 clear", 4'b0000);
        mode_i = 2'd0;
        for (int i = 1; i <= 10; i++) begin
            pulse(0);
            chk($sformatf("R4 bcd step %0d", i), 4'(i % 10));
        end
    endtask

    task automatic t_biq();
        do_clear();
        mode_i = 2'd1;
        for (int i = 1; i <= 10; i++) begin
            pulse(1);
            chk($sformatf("R5 biquinary step %0d", i),
                {3'(i % 5), 1'((i / 5) % 2)});
        end
    endtask

    task automatic t_overrides();
        do_clear();
        mode_i = 2'd0;
        pulse(0); pulse(0);
        chk("R4 count to 2", 4'd2);
        clr_a_i = 1'b1; clr_b_i = 1'b1;
        pulse(0);
        chk("R6 edges discarded during clear", 4'd0);
        clr_b_i = 1'b0;
        pulse(0);
        chk("R8 single clear input ignored", 4'd1);
        clr_a_i = 1'b0;
        nine_a_i = 1'b1; nine_b_i = 1'b1; clr_a_i = 1'b1; clr_b_i = 1'b1;
        wait_n(2);
        chk("R7 preset beats clear", 4'b1001);
        clr_a_i = 1'b0; clr_b_i = 1'b0; nine_a_i = 1'b0;
        pulse(0);
        chk("R4 wrap from preset nine, R8 single preset", 4'd0);
        nine_b_i = 1'b0;
    endtask

    task automatic t_mode_change();
        do_clear();
        mode_i = 2'd0;
        pulse(0); pulse(0); pulse(0);
        chk("R4 count to 3", 4'd3);
        mode_i = 2'd3;
        wait_n(4);
        chk("R9 mode change keeps count", 4'd3);
        pulse(0);
        chk("R10 no cascade after switch to split", 4'b0010);
    endtask

    task automatic t_cascade_timing();
        do_clear();
        mode_i = 2'd0;
        pulse(0);
        cnt0_i = 1'b1;
        wait_n(4);
        cnt0_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (q_o[0] == 1'b0) break;
        end
        n_chk++;
        if (q_o !== 4'b0000) begin
            n_fail++;
            $display("FAIL R10: q_o=%b expected 0000 in fall cycle", q_o);
        end
        @(negedge clk);
        chk("R10 upper stage one cycle later", 4'b0010);
    endtask

    initial begin
        t_reset();
        t_split();
        t_bcd();
        t_biq();
        t_overrides();
        t_mode_change();
        t_cascade_timing();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule